// File: doc/BRIEF.md
# Hardware Breakpoint Address Comparator

This block watches the 16-bit internal address bus of a CPU and asks the interrupt logic for a break when a bus access hits a programmed address. The break address is held as two bytes. Each byte has its own 8-bit equality comparator against its half of the bus, and a hit needs both halves to agree. A small register port on the CPU bus gives access to the two address bytes and to a control byte that holds an enable bit and an active flag.

The CPU side tells the block whether the current access is an opcode fetch. It also pulses a strobe at each instruction boundary, where the CPU samples the request. A hit on an opcode fetch raises the request together with a discard qualifier, so the fetched instruction is dropped and runs only after the service routine returns. A hit on an operand access raises the request without the qualifier, so the running instruction completes first. Software can force a break through the active flag. A hit arms a latch that blocks further hits until software writes a break address byte, so a service routine that only clears the flag is not re-entered at the same address.

Top module: `bkpt_addr_watch`

## Requirements
- R1: After reset, registers at offsets 0, 1 and 2 read 0x00, and brk_req and brk_kill are 0.
- R2: Offset 0 holds break address bits 15:8 and offset 1 holds bits 7:0. Both read back as written. At offset 2, bit 7 is the enable and bit 6 is the active flag. Bits 5:0 read 0 and ignore writes. Offset 3 reads 0x00.
- R3: A bus access with bus_vld=1 at the break address raises no request while the enable bit is 0.
- R4: With enable=1, a bus access with bus_vld=1 and bus_opf=1 at the break address sets the active flag and makes brk_req=1 and brk_kill=1 on the next cycle.
- R5: With enable=1, a bus access with bus_vld=1 and bus_opf=0 at the break address sets the active flag and makes brk_req=1 and brk_kill=0 on the next cycle.
- R6: brk_req and brk_kill stay set through idle cycles. They drop in the cycle after one in which insn_bnd=1.
- R7: Writing 0xC0 to offset 2 sets the active flag and makes brk_req=1 and brk_kill=0 on the next cycle. Writing 0x40 raises no request and leaves the active flag unchanged.
- R8: Writing offset 2 with bit 6=0 clears the active flag. Writing it with bit 7=0 makes brk_req and brk_kill 0 on the next cycle.
- R9: After a hit, further hits raise no request until offset 0 or 1 is written. This holds even after the active flag is cleared.
- R10: Writing either address byte, including with its unchanged value, re-arms the block. A new address together with a cleared active flag yields a new break on its first hit.
- R11: An access whose high byte or low byte alone matches raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 16 | CPU internal address bus |
| bus_vld | input | 1 | An access takes place on bus_addr this cycle |
| bus_opf | input | 1 | The current access is an opcode fetch |
| insn_bnd | input | 1 | Instruction boundary strobe; the CPU takes a pending break here |
| reg_cs | input | 1 | Register port select |
| reg_we | input | 1 | Register port write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| brk_req | output | 1 | Break request to the interrupt logic |
| brk_kill | output | 1 | The break pre-empts the instruction just fetched |

## Verification
A hit, a forced break and a cancelling control write each show on brk_req and brk_kill one clock after the edge that samples them. The request drops one clock after the edge that sees insn_bnd. Read data follows reg_addr within the same cycle, and a register write is visible from the cycle after its edge. The bench drives every stimulus for one full cycle starting at a falling edge and samples at the next falling edge. Each result is therefore read half a cycle after the edge that produced it. Repeat suppression is checked only after idle cycles in which a late request would already have appeared.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  // Decoded register-port write, shared by the register file and the request control.
  typedef struct packed {
    logic wr_addr;  // a break address byte is being written
    logic wr_ctl;   // the control byte is being written
    logic new_en;   // enable value carried by a control write
    logic new_act;  // active value carried by a control write
  } reg_cmd_t;

endpackage

// File: rtl/bkpt_byte_cmp.sv
module bkpt_byte_cmp #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] lhs,
  input  logic [BYTE_W-1:0] rhs,
  output logic              eq
);
  assign eq = (lhs == rhs);
endmodule

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  localparam int NBYTES = ADDR_W / BYTE_W,
  localparam int RA_W   = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_cs,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              act_flag,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] brk_addr,
  output logic              ctl_en,
  output reg_cmd_t          cmd
);
  localparam logic [RA_W-1:0] CTL_OFF = RA_W'(NBYTES);

  logic                wr_any;
  logic [NBYTES-1:0]   byte_we;
  logic [BYTE_W-1:0]   byte_q [NBYTES];
  logic                en_d, en_q;

  assign wr_any = reg_cs & reg_we;

  // Byte 0 is the most significant one.
  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign byte_we[k] = wr_any & (reg_addr == RA_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          byte_q[k] <= '0;
      else if (byte_we[k]) byte_q[k] <= reg_wdata;
    end

    assign brk_addr[ADDR_W-1-k*BYTE_W -: BYTE_W] = byte_q[k];
  end

  assign cmd.wr_addr = |byte_we;
  assign cmd.wr_ctl  = wr_any & (reg_addr == CTL_OFF);
  assign cmd.new_en  = reg_wdata[BYTE_W-1];
  assign cmd.new_act = reg_wdata[BYTE_W-2];

  always_comb begin
    en_d = en_q;
    if (cmd.wr_ctl) en_d = cmd.new_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign ctl_en = en_q;

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NBYTES; k++)
      if (reg_addr == RA_W'(k)) reg_rdata = byte_q[k];
    if (reg_addr == CTL_OFF) begin
      reg_rdata[BYTE_W-1] = en_q;
      reg_rdata[BYTE_W-2] = act_flag;
    end
  end
endmodule

// File: rtl/bkpt_req_ctl.sv
module bkpt_req_ctl
  import bkpt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bus_vld,
  input  logic     bus_opf,
  input  logic     addr_eq,
  input  logic     ctl_en,
  input  logic     insn_bnd,
  input  reg_cmd_t cmd,
  output logic     act_flag,
  output logic     rearm_blk,
  output logic     brk_req,
  output logic     brk_kill
);
  logic hit, force_brk, cancel, clr_act;
  logic act_d, act_q, blk_d, blk_q, req_d, req_q, kill_d, kill_q;

  assign hit       = bus_vld & addr_eq & ctl_en & ~blk_q;
  assign force_brk = cmd.wr_ctl & cmd.new_act & cmd.new_en;
  assign cancel    = cmd.wr_ctl & ~cmd.new_en;
  assign clr_act   = cmd.wr_ctl & ~cmd.new_act;

  always_comb begin
    act_d = act_q;
    if (hit | force_brk) act_d = 1'b1;
    else if (clr_act)    act_d = 1'b0;

    blk_d = blk_q;
    if (cmd.wr_addr) blk_d = 1'b0;
    else if (hit)    blk_d = 1'b1;

    req_d  = req_q;
    kill_d = kill_q;
    if (cancel) begin
      req_d  = 1'b0;
      kill_d = 1'b0;
    end else if (hit) begin
      req_d  = 1'b1;
      kill_d = bus_opf;
    end else if (force_brk) begin
      req_d  = 1'b1;
      kill_d = 1'b0;
    end else if (insn_bnd) begin
      req_d  = 1'b0;
      kill_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      blk_q  <= 1'b0;
      req_q  <= 1'b0;
      kill_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      blk_q  <= blk_d;
      req_q  <= req_d;
      kill_q <= kill_d;
    end
  end

  assign act_flag  = act_q;
  assign rearm_blk = blk_q;
  assign brk_req   = req_q;
  assign brk_kill  = kill_q;
endmodule

// File: rtl/bkpt_addr_watch.sv
module bkpt_addr_watch
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  localparam int NBYTES = ADDR_W / BYTE_W,
  localparam int RA_W   = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_vld,
  input  logic              bus_opf,
  input  logic              insn_bnd,
  input  logic              reg_cs,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              brk_req,
  output logic              brk_kill
);
  logic [1:0]        rst_sync;
  logic              rst_q;
  logic [ADDR_W-1:0] brk_addr;
  logic [NBYTES-1:0] byte_eq;
  logic              addr_eq, ctl_en, act_flag, rearm_blk;
  reg_cmd_t          cmd;

  // Reset asserts at once and is released two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  bkpt_regfile #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q),
    .reg_cs    (reg_cs),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .act_flag  (act_flag),
    .reg_rdata (reg_rdata),
    .brk_addr  (brk_addr),
    .ctl_en    (ctl_en),
    .cmd       (cmd)
  );

  for (genvar k = 0; k < NBYTES; k++) begin : g_cmp
    bkpt_byte_cmp #(.BYTE_W(BYTE_W)) u_cmp (
      .lhs (bus_addr[k*BYTE_W +: BYTE_W]),
      .rhs (brk_addr[k*BYTE_W +: BYTE_W]),
      .eq  (byte_eq[k])
    );
  end
  assign addr_eq = &byte_eq;

  bkpt_req_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_q),
    .bus_vld   (bus_vld),
    .bus_opf   (bus_opf),
    .addr_eq   (addr_eq),
    .ctl_en    (ctl_en),
    .insn_bnd  (insn_bnd),
    .cmd       (cmd),
    .act_flag  (act_flag),
    .rearm_blk (rearm_blk),
    .brk_req   (brk_req),
    .brk_kill  (brk_kill)
  );
endmodule

// File: rtl/bkpt_addr_watch_chk.sv
module bkpt_addr_watch_chk #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  localparam int NBYTES = ADDR_W / BYTE_W,
  localparam int RA_W   = $clog2(NBYTES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_vld,
  input logic              insn_bnd,
  input logic              reg_cs,
  input logic              reg_we,
  input logic [RA_W-1:0]   reg_addr,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic [BYTE_W-1:0] reg_rdata,
  input logic              brk_req,
  input logic              brk_kill,
  input logic              ctl_en,
  input logic              rearm_blk
);
  localparam logic [RA_W-1:0] CTL_OFF = RA_W'(NBYTES);
  logic wr_any, wr_ctl;
  assign wr_any = reg_cs & reg_we;
  assign wr_ctl = wr_any & (reg_addr == CTL_OFF);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTL_OFF) |-> (reg_rdata[BYTE_W-3:0] == '0));

  assert_no_req_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !brk_req && !wr_any) |=> !brk_req);

  assert_kill_with_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    brk_kill |-> brk_req);

  assert_drop_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && insn_bnd && !bus_vld && !wr_any) |=> !brk_req);

  assert_cancel_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !reg_wdata[BYTE_W-1]) |=> (!brk_req && !brk_kill));

  assert_no_refire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_blk && !wr_any && !brk_req) |=> !brk_req);
endmodule

bind bkpt_addr_watch bkpt_addr_watch_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .bus_vld   (bus_vld),
  .insn_bnd  (insn_bnd),
  .reg_cs    (reg_cs),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .brk_req   (brk_req),
  .brk_kill  (brk_kill),
  .ctl_en    (ctl_en),
  .rearm_blk (rearm_blk)
);

// File: tb/bkpt_addr_watch_bench.sv
module bkpt_addr_watch_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OFF_HI = 2'd0, OFF_LO = 2'd1, OFF_CTL = 2'd2;

  typedef struct packed {
    logic [15:0] brk;
    logic [15:0] bus;
    logic        opf;
    logic        en;
    logic        exp_req;
    logic        exp_kill;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{16'h1234, 16'h1234, 1'b1, 1'b1, 1'b1, 1'b1},  // R4 opcode hit
    '{16'h1234, 16'h1234, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 operand hit
    '{16'h1234, 16'h1235, 1'b1, 1'b1, 1'b0, 1'b0},  // R11 low byte differs
    '{16'h1234, 16'h1334, 1'b0, 1'b1, 1'b0, 1'b0},  // R11 high byte differs
    '{16'hABCD, 16'hABCD, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 disabled
    '{16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b0},  // R5
    '{16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1}   // R4
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_vld, bus_opf, insn_bnd;
  logic        reg_cs, reg_we;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        brk_req, brk_kill;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bkpt_addr_watch u_bkpt_addr_watch (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_vld(bus_vld),
    .bus_opf(bus_opf), .insn_bnd(insn_bnd), .reg_cs(reg_cs), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .brk_req(brk_req), .brk_kill(brk_kill)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_cs = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic access(input logic [15:0] a, input logic opf);
    @(negedge clk);
    bus_addr = a; bus_vld = 1'b1; bus_opf = opf;
    @(negedge clk);
    bus_vld = 1'b0; bus_opf = 1'b0;
  endtask

  task automatic boundary();
    @(negedge clk);
    insn_bnd = 1'b1;
    @(negedge clk);
    insn_bnd = 1'b0;
  endtask

  task automatic set_addr(input logic [15:0] a);
    wr(OFF_HI, a[15:8]);
    wr(OFF_LO, a[7:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_vld = 1'b0; bus_opf = 1'b0; insn_bnd = 1'b0;
    reg_cs = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(OFF_HI, d);  check("R1 hi", {8'h0, d}, 16'h0000);
    rd(OFF_LO, d);  check("R1 lo", {8'h0, d}, 16'h0000);
    rd(OFF_CTL, d); check("R1 ctl", {8'h0, d}, 16'h0000);
    check("R1 req/kill", {14'h0, brk_req, brk_kill}, 16'h0000);

    // R2 register map and reserved bits
    wr(OFF_CTL, 8'h3F);
    rd(OFF_CTL, d); check("R2 reserved", {8'h0, d}, 16'h0000);
    set_addr(16'hA55A);
    rd(OFF_HI, d);  check("R2 hi", {8'h0, d}, 16'h00A5);
    rd(OFF_LO, d);  check("R2 lo", {8'h0, d}, 16'h005A);
    rd(2'd3, d);    check("R2 unused offset", {8'h0, d}, 16'h0000);

    // Vector table: R3 R4 R5 R11
    for (int i = 0; i < NVEC; i++) begin
      wr(OFF_CTL, 8'h00);
      set_addr(VEC[i].brk);
      wr(OFF_CTL, {VEC[i].en, 7'h0});
      access(VEC[i].bus, VEC[i].opf);
      check($sformatf("R4/R5/R3/R11 vec%0d req/kill", i),
            {14'h0, brk_req, brk_kill}, {14'h0, VEC[i].exp_req, VEC[i].exp_kill});
      rd(OFF_CTL, d);
      check($sformatf("R4/R5 vec%0d active", i), {8'h0, d},
            {8'h0, VEC[i].en, VEC[i].exp_req, 6'h0});
      boundary();
      check($sformatf("R6 vec%0d cleared", i), {15'h0, brk_req}, 16'h0000);
    end

    // R6 hold through idle cycles
    wr(OFF_CTL, 8'h00);
    set_addr(16'h2000);
    wr(OFF_CTL, 8'h80);
    access(16'h2000, 1'b1);
    repeat (3) @(negedge clk);
    check("R6 held", {14'h0, brk_req, brk_kill}, 16'h0003);
    boundary();
    check("R6 dropped", {14'h0, brk_req, brk_kill}, 16'h0000);

    // R9 repeat hit suppressed, even after the flag is cleared
    access(16'h2000, 1'b1);
    repeat (2) @(negedge clk);
    check("R9 no refire", {15'h0, brk_req}, 16'h0000);
    rd(OFF_CTL, d); check("R9 active kept", {8'h0, d}, 16'h00C0);
    wr(OFF_CTL, 8'h80);
    rd(OFF_CTL, d); check("R8 active cleared", {8'h0, d}, 16'h0080);
    access(16'h2000, 1'b0);
    repeat (2) @(negedge clk);
    check("R9 no refire after clear", {15'h0, brk_req}, 16'h0000);

    // R10 rewrite of unchanged byte re-arms
    wr(OFF_LO, 8'h00);
    access(16'h2000, 1'b0);
    check("R10 rearm same value", {14'h0, brk_req, brk_kill}, 16'h0002);
    boundary();
    // R10 stream: new address and cleared flag
    set_addr(16'h2004);
    wr(OFF_CTL, 8'h80);
    access(16'h2004, 1'b1);
    check("R10 stream break", {14'h0, brk_req, brk_kill}, 16'h0003);

    // R8 disabling cancels a pending request
    wr(OFF_CTL, 8'h00);
    check("R8 cancel", {14'h0, brk_req, brk_kill}, 16'h0000);
    rd(OFF_CTL, d); check("R8 ctl after cancel", {8'h0, d}, 16'h0000);

    // R7 forced break
    wr(OFF_CTL, 8'hC0);
    check("R7 forced", {14'h0, brk_req, brk_kill}, 16'h0002);
    rd(OFF_CTL, d); check("R7 ctl", {8'h0, d}, 16'h00C0);
    boundary();
    check("R7 taken at boundary", {15'h0, brk_req}, 16'h0000);
    wr(OFF_CTL, 8'h00);
    wr(OFF_CTL, 8'h40);
    check("R7 no force when disabled", {15'h0, brk_req}, 16'h0000);
    rd(OFF_CTL, d); check("R7 flag unchanged", {8'h0, d}, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule